// File: doc/BRIEF.md
# Processor Event Wait Unit

This unit holds a small processor core in a stalled state until one chosen event occurs, then lets it run again. Instead of diverting the core to a handler, the core simply stops at the wait point and resumes when the event arrives. Two kinds of event are supported. A pin wait looks at a 32-bit input pin bus through a mask and waits for it to equal a target pattern. A counter wait waits for the free-running system counter to reach one exact value.

While a wait is pending, the unit drops a clock-enable output so that the core's clock is gated off. Only the unit's own few flip-flops keep running, which keeps idle power low. The pin inputs are resynchronized through two flops before they are compared. Release is signalled by a one-cycle done pulse, and stall drops in that same cycle.

Top module: `evt_wait_unit`

## Requirements
- R1: After reset, stall and done are 0 and core_clk_en is 1.
- R2: A pin wait (req_kind = 0) completes when the synchronized pins ANDed with the captured mask equal the captured target pattern; pin bits outside the mask have no effect.
- R3: A counter wait (req_kind = 1) completes only in the cycle after a clock edge at which sys_count exactly equals the captured count; at every other value the stall is held.
- R4: stall is 1 from the cycle after an accepted request until release, and core_clk_en is 0 exactly while stall is 1.
- R5: done is a single-cycle pulse. It is high in the first cycle that stall is low after a wait. A pin change satisfying the condition produces done after the third rising edge (two synchronizer stages and one compare edge).
- R6: A counter wait whose count has already been passed keeps the stall until sys_count wraps past all-ones and reaches the count.
- R7: A request presented while a wait is pending is ignored; the pending wait keeps its kind, mask, target and count.
- R8: A pin wait whose condition already holds on the synchronized pins when it is accepted completes at the next rising edge, so stall is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Wait request strobe |
| req_kind | input | 1 | 0 = pin wait, 1 = counter wait |
| req_mask | input | 32 | Pin mask for a pin wait |
| req_target | input | 32 | Pin pattern for a pin wait |
| req_count | input | 32 | Counter value for a counter wait |
| pins_in | input | 32 | Asynchronous pin bus |
| sys_count | input | 32 | Free-running system counter |
| stall | output | 1 | Core is held |
| done | output | 1 | One-cycle release pulse |
| core_clk_en | output | 1 | Enable for the core's gated clock |

## Verification
The hardest case to reach is the counter wait armed after its count has passed, since a real 32-bit counter would need billions of cycles to wrap. The bench owns sys_count as a plain input. It lets the count run for a while to show the stall holds, then jumps it just below all-ones and counts it through the wrap to the target. The ignored-request case is reached by arming a pin wait that cannot match, then offering a counter request whose count is passed during the stall.

// File: rtl/evt_wait_unit.sv
module evt_wait_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic         req_kind,
  input  logic [W-1:0] req_mask,
  input  logic [W-1:0] req_target,
  input  logic [W-1:0] req_count,
  input  logic [W-1:0] pins_in,
  input  logic [W-1:0] sys_count,
  output logic         stall,
  output logic         done,
  output logic         core_clk_en
);
  logic         pend_q, done_q, mode_q;
  logic [W-1:0] mask_q, pat_q, cnt_q, sync1_q, sync2_q;
  logic         hit;

  assign hit = mode_q ? (sys_count == cnt_q) : ((sync2_q & mask_q) == pat_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= 1'b0;
      mask_q  <= '0;
      pat_q   <= '0;
      cnt_q   <= '0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pins_in;
      sync2_q <= sync1_q;
      done_q  <= pend_q && hit;
      if (!pend_q && req_valid) begin
        pend_q <= 1'b1;
        mode_q <= req_kind;
        mask_q <= req_mask;
        pat_q  <= req_target;
        cnt_q  <= req_count;
      end else if (pend_q && hit) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign stall       = pend_q;
  assign done        = done_q;
  assign core_clk_en = ~pend_q;
endmodule

module evt_wait_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         stall,
  input logic         done,
  input logic         mode_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] pat_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] sync2_q,
  input logic [W-1:0] sys_count
);
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_unstalled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall);

  p_release_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> done);

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && mode_q && sys_count != cnt_q) |=> stall);

  p_pin_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !mode_q && ((sync2_q & mask_q) == pat_q)) |=> (!stall && done));

  p_req_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(mode_q) && $stable(mask_q) && $stable(pat_q) && $stable(cnt_q)));
endmodule

bind evt_wait_unit evt_wait_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .done(done), .mode_q(mode_q),
  .mask_q(mask_q), .pat_q(pat_q), .cnt_q(cnt_q), .sync2_q(sync2_q),
  .sys_count(sys_count)
);

// File: tb/test_evt_wait_unit.sv
module test_evt_wait_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_kind = 1'b0;
  logic [31:0] req_mask = '0, req_target = '0, req_count = '0;
  logic [31:0] pins_in = '0, sys_count = '0;
  logic        stall, done, core_clk_en;
  int          n_run = 0, n_fail = 0;
  bit          finished = 1'b0;

  evt_wait_unit i_evt_wait_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_mask(req_mask), .req_target(req_target), .req_count(req_count),
    .pins_in(pins_in), .sys_count(sys_count), .stall(stall), .done(done),
    .core_clk_en(core_clk_en)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    sys_count = sys_count + 32'd1;
  endtask

  task automatic state(input logic s, input logic d, input string tag);
    check(stall == s && done == d && core_clk_en == !s, tag,
          {29'd0, stall, done, core_clk_en}, {29'd0, s, d, !s});
  endtask

  task automatic issue(input logic kind, input logic [31:0] m, input logic [31:0] t, input logic [31:0] c);
    req_valid = 1'b1; req_kind = kind; req_mask = m; req_target = t; req_count = c;
    step();
    req_valid = 1'b0; req_mask = '0; req_target = '0; req_count = '0;
  endtask

  task automatic run_to_count(input logic [31:0] tgt, input int limit, input string tag);
    for (int i = 0; i < limit; i++) begin
      logic [31:0] seen;
      seen = sys_count;
      step();
      if (seen == tgt) begin
        state(1'b0, 1'b1, tag);
        step();
        state(1'b0, 1'b0, {tag, " pulse"});
        return;
      end
      if (stall !== 1'b1 || done !== 1'b0) begin
        state(1'b1, 1'b0, tag);
        return;
      end
    end
    check(1'b0, {tag, " timeout"}, 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    state(1'b0, 1'b0, "R1 reset");
  endtask

  task automatic t_pin_ready();
    pins_in = 32'h1234_00A5;
    repeat (3) step();
    issue(1'b0, 32'h0000_00FF, 32'h0000_00A5, 32'h0);
    state(1'b1, 1'b0, "R8 stall one cycle");
    step();
    state(1'b0, 1'b1, "R8 release next clock");
    step();
    state(1'b0, 1'b0, "R5 done single cycle");
  endtask

  task automatic t_pin_latency();
    pins_in = 32'h0;
    repeat (3) step();
    issue(1'b0, 32'h0000_00F0, 32'h0000_0030, 32'h0);
    pins_in = 32'hFFFF_FF0F;
    repeat (5) step();
    state(1'b1, 1'b0, "R2 unmasked bits ignored");
    pins_in = 32'hABCD_123F;
    step(); step();
    state(1'b1, 1'b0, "R5 synchronizer latency");
    step();
    state(1'b0, 1'b1, "R2 masked match releases");
    step();
    state(1'b0, 1'b0, "R5 pulse ends");
  endtask

  task automatic t_counter();
    sys_count = 32'd1000;
    issue(1'b1, 32'h0, 32'h0, 32'd1010);
    state(1'b1, 1'b0, "R4 stall after request");
    run_to_count(32'd1010, 40, "R3 exact count");
  endtask

  task automatic t_wrap();
    sys_count = 32'd2000;
    issue(1'b1, 32'h0, 32'h0, 32'd50);
    repeat (20) step();
    state(1'b1, 1'b0, "R6 passed target holds");
    sys_count = 32'hFFFF_FFF0;
    run_to_count(32'd50, 200, "R6 wrap release");
  endtask

  task automatic t_ignore();
    pins_in = 32'h0;
    repeat (3) step();
    issue(1'b0, 32'h0000_0001, 32'h0000_0001, 32'h0);
    req_valid = 1'b1; req_kind = 1'b1; req_count = sys_count + 32'd3;
    req_mask = 32'h0; req_target = 32'h0;
    step();
    req_valid = 1'b0;
    repeat (10) step();
    state(1'b1, 1'b0, "R7 second request ignored");
    pins_in = 32'h0000_0001;
    repeat (3) step();
    state(1'b0, 1'b1, "R7 original pin wait kept");
    step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_pin_ready();
    t_pin_latency();
    t_counter();
    t_wrap();
    t_ignore();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #800000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule